// File: doc/BRIEF.md
# Oversampling Serial Receiver with Receive Queue

This block is the receive half of an asynchronous serial port that follows the classic PC serial-port register model. A 16-bit divisor turns either the system clock or a slower external baud clock into a sampling tick at sixteen times the bit rate. The deframer watches the synchronized serial input and drops start pulses that do not last to mid-bit. It then assembles characters of five to eight data bits, least-significant bit first. When parity is enabled it checks an even or odd parity bit, and it always checks the first stop bit.

Each completed character goes into a 16-entry first-in first-out queue together with three flags: parity error, framing error and break. The head of the queue is always visible on the read ports, and a one-cycle read strobe removes it. When the queue is switched off, it shrinks to a single holding register. Three indications are provided for the host side: data ready, a trigger-level request whose threshold is set by a 2-bit field, and a character time-out that fires when characters sit unread and the line has gone quiet.

Top module: `uart_rx_fifo`

## Requirements
- R1: The sampling tick occurs once every max(`divisor`,1) source clocks. The source is the system clock when `use_baud_clk` is 0, or each synchronized rising edge of `baud_clk` when it is 1, with `baud_clk` slower than half the system clock. One bit lasts 16 ticks.
- R2: `len_sel` selects 5, 6, 7 or 8 data bits for codes 0, 1, 2 and 3. Bits arrive least-significant first after one low start bit. The character is right-aligned on `rd_data`, with the unused upper bits at zero.
- R3: With `par_en`=1, one parity bit follows the data. `par_odd`=0 expects an even count of ones over data plus parity, and `par_odd`=1 expects an odd count. A mismatch sets `rd_par_err` for that character. With `par_en`=0 the flag is always 0.
- R4: Only the first stop bit is sampled. If it is low, `rd_frm_err` is set, and the receiver waits for the line to return high before it looks for the next start bit.
- R5: A low pulse on `rxd` that is no longer low at mid-bit of the start bit produces no character, and the receiver goes back to hunting for a start bit.
- R6: A frame in which every sampled bit (data, parity and stop) is low produces exactly one entry, with data 0, `rd_brk`=1 and `rd_frm_err`=1. No further entry is made until the line has returned high.
- R7: With `fifo_en`=1, up to 16 characters are held in arrival order. The oldest is shown on `rd_data` and the flag ports, and `rd_en` removes it. `data_ready` is 1 exactly when the queue is not empty.
- R8: A character that completes while the queue is full, with no read in the same cycle, is discarded. The stored entries are kept, and `overrun` pulses high for one cycle.
- R9: With `fifo_en`=0 the queue holds at most one character. Any change of `fifo_en` empties the queue.
- R10: In FIFO mode, `trig_irq` is high while the fill level is at least 1, 4, 8 or 14 for `trig_sel` codes 0, 1, 2 and 3. In non-FIFO mode `trig_irq` equals `data_ready`.
- R11: In FIFO mode, `tout_irq` rises when the queue is not empty and no character has completed and no read has occurred for 4 character times. One character time is 16 × (start + data bits + parity + 1 stop) ticks. A read or a new character clears it. In non-FIFO mode it stays low.
- R12: After reset the queue is empty, and `data_ready`, `trig_irq`, `tout_irq`, `overrun` and all read ports are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_clk | input | 1 | Optional external baud clock, slower than clk/2 |
| use_baud_clk | input | 1 | 1: divisor counts baud_clk rising edges; 0: counts clk cycles |
| divisor | input | 16 | Tick divisor (0 behaves as 1) |
| rxd | input | 1 | Serial input, idle high |
| len_sel | input | 2 | Data bits: 0=5, 1=6, 2=7, 3=8 |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 odd parity, 0 even parity |
| fifo_en | input | 1 | 1: 16-entry queue; 0: single holding register |
| trig_sel | input | 2 | Trigger level: 0=1, 1=4, 2=8, 3=14 |
| rd_en | input | 1 | Removes the head entry |
| rd_data | output | 8 | Head character, right-aligned |
| rd_par_err | output | 1 | Head parity-error flag |
| rd_frm_err | output | 1 | Head framing-error flag |
| rd_brk | output | 1 | Head break flag |
| data_ready | output | 1 | Queue not empty |
| overrun | output | 1 | One-cycle pulse when a character is discarded |
| trig_irq | output | 1 | Fill level at or above the trigger |
| tout_irq | output | 1 | Character time-out |

## Verification
The bench targets the masking of 5- to 7-bit characters and an all-zero character with a good stop bit. A design that mis-sized the shift would return shifted or polluted data, and one that confused zero data with a break would set the break flag. A short start glitch and a long low line come next: a receiver without the mid-bit recheck would store a spurious character, and one that did not wait for the line to go high after a break would fill the queue with zeros. The queue is then filled to the brim and one more character is sent, so a design that overwrote an entry or lost the pulse shows up. The time-out is sampled just before and just after its four-character window, and the holding-register mode is checked for its depth of one, its flush on mode change, and a time-out that never fires.

// File: rtl/urx_pkg.sv
// Shared types for the serial receive path.
package urx_pkg;

    // One queued character with its per-character status.
    typedef struct packed {
        logic       brk;
        logic       ferr;
        logic       perr;
        logic [7:0] data;
    } rx_word_t;

    // Deframer states.
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_WAIT_HI
    } rx_state_t;

endpackage

// File: rtl/urx_baud_tick.sv
// Produces the 16x sampling tick.
// Counts either system clocks or synchronized rising edges of an external
// baud clock, and emits one tick per divisor counts.
// Assumes baud_clk is slower than half of clk; divisor 0 acts as 1.
module urx_baud_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_sel,
    input  logic             baud_clk,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);

    logic [2:0]       bsync;
    logic [DIV_W-1:0] cnt;
    logic             src_en;

    // Synchronize the external clock and keep one delayed copy for edge detect.
    always_ff @(posedge clk) begin
        if (!rst_n) bsync <= '0;
        else        bsync <= {bsync[1:0], baud_clk};
    end

    // Select the count source.
    always_comb begin
        src_en = ext_sel ? (bsync[1] & ~bsync[2]) : 1'b1;
    end

    // Down-counter that reloads from the divisor and emits the tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            tick <= 1'b0;
            if (src_en) begin
                if (cnt == '0) begin
                    tick <= 1'b1;
                    cnt  <= (divisor == '0) ? '0 : divisor - DIV_ONE;
                end else begin
                    cnt <= cnt - DIV_ONE;
                end
            end
        end
    end

    AST_EXT_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n) (ext_sel && $past(ext_sel) && tick) |=> !tick); // R1

endmodule

// File: rtl/urx_deframer.sv
// Serial deframer working on 16x sampling ticks.
// Finds a start bit and confirms it at mid-bit, then samples data, the
// optional parity and the first stop bit at the centre of each bit. Each
// completed frame is delivered as a one-cycle push with its error flags.
// Assumes the configuration is stable while a frame is in flight.
module urx_deframer
    import urx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd,
    input  logic [1:0] len_sel,
    input  logic       par_en,
    input  logic       par_odd,
    output logic       push_valid,
    output rx_word_t   push_word
);
    localparam logic [3:0] MID_CNT = 4'd7;
    localparam logic [3:0] END_CNT = 4'd15;

    rx_state_t  state;
    logic [1:0] rsync;
    logic       rx;
    logic [3:0] scnt;
    logic [2:0] bidx;
    logic [2:0] last_idx;
    logic [7:0] shreg;
    logic [7:0] data_al;
    logic       par_acc;
    logic       saw_one;

    // Two-flop synchronizer on the serial input, idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) rsync <= 2'b11;
        else        rsync <= {rsync[0], rxd};
    end

    // Index of the last data bit and the right-aligned character.
    always_comb begin
        rx       = rsync[1];
        last_idx = {1'b0, len_sel} + 3'd4;
        data_al  = shreg >> (2'd3 - len_sel);
    end

    // Frame state machine, advanced only on sampling ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= RX_IDLE;
            scnt       <= '0;
            bidx       <= '0;
            shreg      <= '0;
            par_acc    <= 1'b0;
            saw_one    <= 1'b0;
            push_valid <= 1'b0;
            push_word  <= '0;
        end else begin
            push_valid <= 1'b0;
            if (tick) begin
                case (state)
                    RX_IDLE: begin
                        if (!rx) begin
                            state <= RX_START;
                            scnt  <= '0;
                        end
                    end
                    RX_START: begin
                        if (scnt == MID_CNT) begin
                            scnt <= '0;
                            if (rx) begin
                                state <= RX_IDLE;
                            end else begin
                                state   <= RX_DATA;
                                bidx    <= '0;
                                par_acc <= 1'b0;
                                saw_one <= 1'b0;
                            end
                        end else begin
                            scnt <= scnt + 4'd1;
                        end
                    end
                    RX_DATA: begin
                        if (scnt == END_CNT) begin
                            scnt    <= '0;
                            shreg   <= {rx, shreg[7:1]};
                            par_acc <= par_acc ^ rx;
                            saw_one <= saw_one | rx;
                            if (bidx == last_idx) state <= par_en ? RX_PAR : RX_STOP;
                            else                  bidx  <= bidx + 3'd1;
                        end else begin
                            scnt <= scnt + 4'd1;
                        end
                    end
                    RX_PAR: begin
                        if (scnt == END_CNT) begin
                            scnt    <= '0;
                            par_acc <= par_acc ^ rx;
                            saw_one <= saw_one | rx;
                            state   <= RX_STOP;
                        end else begin
                            scnt <= scnt + 4'd1;
                        end
                    end
                    RX_STOP: begin
                        if (scnt == END_CNT) begin
                            scnt            <= '0;
                            push_valid      <= 1'b1;
                            push_word.data  <= data_al;
                            push_word.perr  <= par_en & (par_acc ^ par_odd);
                            push_word.ferr  <= ~rx;
                            push_word.brk   <= ~rx & ~saw_one;
                            state           <= rx ? RX_IDLE : RX_WAIT_HI;
                        end else begin
                            scnt <= scnt + 4'd1;
                        end
                    end
                    RX_WAIT_HI: begin
                        if (rx) state <= RX_IDLE;
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    AST_FALSE_START: assert property (@(posedge clk) disable iff (!rst_n) (state == RX_START && tick && scnt == MID_CNT && rx) |=> (state == RX_IDLE && !push_valid)); // R5
    AST_BRK_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (push_valid && push_word.brk) |-> (push_word.data == '0 && push_word.ferr)); // R6
    AST_BRK_WAITS:   assert property (@(posedge clk) disable iff (!rst_n) (push_valid && push_word.ferr) |-> state == RX_WAIT_HI); // R4

endmodule

// File: rtl/urx_fifo.sv
// Receive queue with show-ahead head output.
// In FIFO mode up to DEPTH words are kept; otherwise the capacity is one.
// A push while full, without a pop in the same cycle, is dropped and
// reported as a one-cycle overrun. Any change of the mode flushes the queue.
// Assumes DEPTH >= 2.
module urx_fifo
    import urx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             push,
    input  rx_word_t         wdata,
    input  logic             pop,
    output rx_word_t         rdata,
    output logic [CNT_W-1:0] count,
    output logic             overrun
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
    localparam logic [AW-1:0]    PTR_END = AW'(DEPTH - 1);

    rx_word_t         mem [DEPTH];
    logic [AW-1:0]    wp;
    logic [AW-1:0]    rp;
    logic             fifo_en_q;
    logic             flush;
    logic [CNT_W-1:0] cap;
    logic             do_push;
    logic             do_pop;

    // Accept and remove decisions for this cycle.
    always_comb begin
        flush   = fifo_en ^ fifo_en_q;
        cap     = fifo_en ? CNT_MAX : CNT_ONE;
        do_pop  = pop && (count != '0) && !flush;
        do_push = push && !flush && ((count != cap) || do_pop);
        rdata   = mem[rp];
    end

    // Storage write, no reset needed.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    // Pointers, fill level, mode history and overrun pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp        <= '0;
            rp        <= '0;
            count     <= '0;
            fifo_en_q <= fifo_en;
            overrun   <= 1'b0;
        end else begin
            fifo_en_q <= fifo_en;
            overrun   <= push && !do_push && !flush;
            if (flush) begin
                wp    <= '0;
                rp    <= '0;
                count <= '0;
            end else begin
                if (do_push) wp <= (wp == PTR_END) ? '0 : wp + AW'(1);
                if (do_pop)  rp <= (rp == PTR_END) ? '0 : rp + AW'(1);
                case ({do_push, do_pop})
                    2'b10:   count <= count + CNT_ONE;
                    2'b01:   count <= count - CNT_ONE;
                    default: count <= count;
                endcase
            end
        end
    end

    AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) count <= CNT_MAX); // R7
    AST_HOLD_ONE:     assert property (@(posedge clk) disable iff (!rst_n) (!fifo_en && !$past(fifo_en)) |-> count <= CNT_ONE); // R9
    AST_OVR_KEEPS:    assert property (@(posedge clk) disable iff (!rst_n) overrun |-> $stable(count)); // R8
    AST_POP_DECR:     assert property (@(posedge clk) disable iff (!rst_n) (pop && count != '0 && !push && !flush) |=> count == $past(count) - CNT_ONE); // R7

endmodule

// File: rtl/urx_flags.sv
// Host-side indications derived from the queue fill level.
// The trigger request compares the fill level with a selectable threshold.
// The time-out counts sampling ticks while characters wait and nothing
// happens, and fires after TOUT_CHARS character times.
// Assumes DEPTH >= 14 so that every threshold is reachable.
module urx_flags #(
    parameter int DEPTH      = 16,
    parameter int TOUT_CHARS = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int TW    = $clog2(12 * 16 * TOUT_CHARS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             fifo_en,
    input  logic [1:0]       trig_sel,
    input  logic [1:0]       len_sel,
    input  logic             par_en,
    input  logic [CNT_W-1:0] count,
    input  logic             char_done,
    input  logic             rd_en,
    output logic             trig_irq,
    output logic             tout_irq
);
    logic [CNT_W-1:0] level;
    logic [3:0]       frame_bits;
    logic [TW-1:0]    tlimit;
    logic [TW-1:0]    tcnt;
    logic             quiet_reset;

    // Threshold decode, frame length and time-out limit.
    always_comb begin
        case (trig_sel)
            2'd0:    level = CNT_W'(1);
            2'd1:    level = CNT_W'(4);
            2'd2:    level = CNT_W'(8);
            default: level = CNT_W'(14);
        endcase
        frame_bits  = 4'd7 + {2'b00, len_sel} + {3'b000, par_en};
        tlimit      = TW'(frame_bits) * TW'(16 * TOUT_CHARS);
        trig_irq    = fifo_en ? (count >= level) : (count != '0);
        quiet_reset = !fifo_en || (count == '0) || char_done || rd_en;
    end

    // Idle tick counter and time-out flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcnt     <= '0;
            tout_irq <= 1'b0;
        end else if (quiet_reset) begin
            tcnt     <= '0;
            tout_irq <= 1'b0;
        end else if (tick && !tout_irq) begin
            tcnt <= tcnt + TW'(1);
            if (tcnt == tlimit - TW'(1)) tout_irq <= 1'b1;
        end
    end

    AST_TOUT_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n) tout_irq |-> (count != '0 && fifo_en)); // R11
    AST_TOUT_CLEARS:   assert property (@(posedge clk) disable iff (!rst_n) (rd_en && tout_irq) |=> !tout_irq); // R11

endmodule

// File: rtl/uart_rx_fifo.sv
// Top of the serial receive path: tick generator, deframer, receive queue
// and host indications. Read ports show the head entry and read as zero
// while the queue is empty.
module uart_rx_fifo
    import urx_pkg::*;
#(
    parameter int DIV_W      = 16,
    parameter int FIFO_DEPTH = 16,
    parameter int TOUT_CHARS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             baud_clk,
    input  logic             use_baud_clk,
    input  logic [DIV_W-1:0] divisor,
    input  logic             rxd,
    input  logic [1:0]       len_sel,
    input  logic             par_en,
    input  logic             par_odd,
    input  logic             fifo_en,
    input  logic [1:0]       trig_sel,
    input  logic             rd_en,
    output logic [7:0]       rd_data,
    output logic             rd_par_err,
    output logic             rd_frm_err,
    output logic             rd_brk,
    output logic             data_ready,
    output logic             overrun,
    output logic             trig_irq,
    output logic             tout_irq
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    logic             tick;
    logic             push_valid;
    rx_word_t         push_word;
    rx_word_t         head;
    logic [CNT_W-1:0] count;

    urx_baud_tick #(.DIV_W(DIV_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_sel  (use_baud_clk),
        .baud_clk (baud_clk),
        .divisor  (divisor),
        .tick     (tick)
    );

    urx_deframer u_deframer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .rxd        (rxd),
        .len_sel    (len_sel),
        .par_en     (par_en),
        .par_odd    (par_odd),
        .push_valid (push_valid),
        .push_word  (push_word)
    );

    urx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .fifo_en (fifo_en),
        .push    (push_valid),
        .wdata   (push_word),
        .pop     (rd_en),
        .rdata   (head),
        .count   (count),
        .overrun (overrun)
    );

    urx_flags #(.DEPTH(FIFO_DEPTH), .TOUT_CHARS(TOUT_CHARS)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .fifo_en   (fifo_en),
        .trig_sel  (trig_sel),
        .len_sel   (len_sel),
        .par_en    (par_en),
        .count     (count),
        .char_done (push_valid),
        .rd_en     (rd_en),
        .trig_irq  (trig_irq),
        .tout_irq  (tout_irq)
    );

    // Head presentation, zeroed while empty.
    always_comb begin
        data_ready = (count != '0);
        rd_data    = data_ready ? head.data : '0;
        rd_par_err = data_ready & head.perr;
        rd_frm_err = data_ready & head.ferr;
        rd_brk     = data_ready & head.brk;
    end

    AST_TRIG_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n) trig_irq |-> data_ready); // R10

endmodule

// File: tb/tb_uart_rx_fifo.sv
`timescale 1ns/1ps
module tb_uart_rx_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        baud_clk = 1'b0;
    logic        use_baud_clk = 1'b0;
    logic [15:0] divisor = 16'd2;
    logic        rxd = 1'b1;
    logic [1:0]  len_sel = 2'd3;
    logic        par_en = 1'b0;
    logic        par_odd = 1'b0;
    logic        fifo_en = 1'b1;
    logic [1:0]  trig_sel = 2'd0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic        rd_par_err, rd_frm_err, rd_brk;
    logic        data_ready, overrun, trig_irq, tout_irq;

    int n_chk = 0;
    int n_fail = 0;
    int ovr_seen = 0;
    int bdiv = 0;

    uart_rx_fifo dut (
        .clk(clk), .rst_n(rst_n), .baud_clk(baud_clk), .use_baud_clk(use_baud_clk),
        .divisor(divisor), .rxd(rxd), .len_sel(len_sel), .par_en(par_en),
        .par_odd(par_odd), .fifo_en(fifo_en), .trig_sel(trig_sel), .rd_en(rd_en),
        .rd_data(rd_data), .rd_par_err(rd_par_err), .rd_frm_err(rd_frm_err),
        .rd_brk(rd_brk), .data_ready(data_ready), .overrun(overrun),
        .trig_irq(trig_irq), .tout_irq(tout_irq)
    );

    always #2 clk = ~clk;

    // External baud clock: period of 6 system clocks.
    always @(negedge clk) begin
        if (bdiv == 2) begin bdiv <= 0; baud_clk <= ~baud_clk; end
        else bdiv <= bdiv + 1;
    end

    always @(negedge clk) if (overrun === 1'b1) ovr_seen++;

    // {len_sel, par_en, par_odd, bad_parity, bad_stop, data}
    localparam int NV = 9;
    localparam logic [13:0] VECS [NV] = '{
        {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5},
        {2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 8'h5A},
        {2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h13},
        {2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h2C},
        {2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 8'h80},
        {2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 8'h3C},
        {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF},
        {2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 8'h7F},
        {2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}
    };

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] len_mask(logic [1:0] l);
        return 8'hFF >> (2'd3 - l);
    endfunction

    task automatic send_frame(int bt, logic [1:0] l, bit pe, bit po, logic [7:0] d, bit bad_p, bit bad_s);
        logic [7:0] dm;
        dm = d & len_mask(l);
        rxd = 1'b0; repeat (bt) @(negedge clk);
        for (int i = 0; i < int'(l) + 5; i++) begin
            rxd = d[i]; repeat (bt) @(negedge clk);
        end
        if (pe) begin
            rxd = (^dm) ^ po ^ bad_p; repeat (bt) @(negedge clk);
        end
        rxd = ~bad_s; repeat (bt) @(negedge clk);
        rxd = 1'b1; repeat (bt) @(negedge clk);
    endtask

    task automatic pop_chk(string req, logic [7:0] d, bit pe, bit fe, bit bk);
        chk(req, "data_ready", data_ready, 1);
        chk(req, "rd_data", rd_data, d);
        chk(req, "rd_par_err", rd_par_err, pe);
        chk(req, "rd_frm_err", rd_frm_err, fe);
        chk(req, "rd_brk", rd_brk, bk);
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0; @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int base;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12", "data_ready", data_ready, 0);
        chk("R12", "trig_irq", trig_irq, 0);
        chk("R12", "tout_irq", tout_irq, 0);
        chk("R12", "overrun", overrun, 0);
        chk("R12", "rd_data", rd_data, 0);
        repeat (40) @(negedge clk);

        // Vector table: R2 length/masking, R3 parity, R4 stop, R7 ordering
        for (int v = 0; v < NV; v++) begin
            logic [13:0] e;
            e = VECS[v];
            len_sel = e[13:12]; par_en = e[11]; par_odd = e[10];
            @(negedge clk);
            send_frame(32, e[13:12], e[11], e[10], e[7:0], e[9], e[8]);
            pop_chk("R2_R3_R4", e[7:0] & len_mask(e[13:12]), e[11] & e[9], e[8], 1'b0);
            chk("R7", "empty after read", data_ready, 0);
        end
        len_sel = 2'd3; par_en = 1'b0; par_odd = 1'b0;

        // R5 false start glitch
        rxd = 1'b0; repeat (10) @(negedge clk); rxd = 1'b1;
        repeat (96) @(negedge clk);
        chk("R5", "no char after glitch", data_ready, 0);
        send_frame(32, 2'd3, 0, 0, 8'h66, 0, 0);
        pop_chk("R5", 8'h66, 0, 0, 0);

        // R6 break: line low for many frames
        rxd = 1'b0; repeat (25 * 32) @(negedge clk);
        rxd = 1'b1; repeat (64) @(negedge clk);
        pop_chk("R6", 8'h00, 0, 1, 1);
        chk("R6", "single break entry", data_ready, 0);

        // R10 trigger thresholds, R7 order
        trig_sel = 2'd1;
        for (int i = 0; i < 3; i++) send_frame(32, 2'd3, 0, 0, 8'hB0 + 8'(i), 0, 0);
        chk("R10", "below level 4", trig_irq, 0);
        send_frame(32, 2'd3, 0, 0, 8'hB3, 0, 0);
        chk("R10", "at level 4", trig_irq, 1);
        trig_sel = 2'd2; @(negedge clk);
        chk("R10", "below level 8", trig_irq, 0);
        trig_sel = 2'd3; @(negedge clk);
        chk("R10", "below level 14", trig_irq, 0);
        trig_sel = 2'd0; @(negedge clk);
        chk("R10", "at level 1", trig_irq, 1);
        for (int i = 0; i < 4; i++) pop_chk("R7", 8'hB0 + 8'(i), 0, 0, 0);

        // R11 time-out window: 4 x 10 bits x 16 ticks x 2 clocks = 1280 clocks
        trig_sel = 2'd3;
        send_frame(32, 2'd3, 0, 0, 8'h77, 0, 0);
        repeat (1000) @(negedge clk);
        chk("R11", "tout before window", tout_irq, 0);
        repeat (400) @(negedge clk);
        chk("R11", "tout after window", tout_irq, 1);
        chk("R10", "trig stays low", trig_irq, 0);
        pop_chk("R11", 8'h77, 0, 0, 0);
        chk("R11", "tout cleared by read", tout_irq, 0);

        // R8 overrun with a full queue
        base = ovr_seen;
        for (int i = 0; i < 16; i++) send_frame(32, 2'd3, 0, 0, 8'h10 + 8'(i), 0, 0);
        chk("R8", "no overrun at 16", ovr_seen - base, 0);
        chk("R10", "level 14 reached", trig_irq, 1);
        send_frame(32, 2'd3, 0, 0, 8'hEE, 0, 0);
        chk("R8", "overrun pulse", ovr_seen - base, 1);
        for (int i = 0; i < 16; i++) pop_chk("R8", 8'h10 + 8'(i), 0, 0, 0);
        chk("R8", "extra char dropped", data_ready, 0);

        // R9 holding-register mode
        fifo_en = 1'b0; repeat (3) @(negedge clk);
        base = ovr_seen;
        send_frame(32, 2'd3, 0, 0, 8'h41, 0, 0);
        chk("R10", "non-fifo trig", trig_irq, 1);
        send_frame(32, 2'd3, 0, 0, 8'h42, 0, 0);
        chk("R9", "overrun at depth 1", ovr_seen - base, 1);
        pop_chk("R9", 8'h41, 0, 0, 0);
        chk("R9", "depth one", data_ready, 0);
        chk("R10", "non-fifo trig low", trig_irq, 0);
        send_frame(32, 2'd3, 0, 0, 8'h43, 0, 0);
        repeat (2000) @(negedge clk);
        chk("R11", "no tout in non-fifo", tout_irq, 0);
        fifo_en = 1'b1; repeat (2) @(negedge clk);
        chk("R9", "mode change flushes", data_ready, 0);

        // R1 external baud clock: 6 clocks per tick, 96 clocks per bit
        use_baud_clk = 1'b1; divisor = 16'd1; par_en = 1'b1; par_odd = 1'b0;
        repeat (200) @(negedge clk);
        send_frame(96, 2'd3, 1, 0, 8'hC3, 0, 0);
        pop_chk("R1", 8'hC3, 0, 0, 0);
        // R1 system clock with divisor 3: 48 clocks per bit
        use_baud_clk = 1'b0; divisor = 16'd3;
        repeat (100) @(negedge clk);
        send_frame(48, 2'd3, 1, 0, 8'h3E, 0, 0);
        pop_chk("R1", 8'h3E, 0, 0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule